// File: doc/BRIEF.md
# T1 Bipolar Line Codec

This block sits between a T1 framer and the line driver. On the transmit side it turns a unipolar 1.544 Mbit/s bit stream into a pair of rail bits, one for positive marks and one for negative marks, produced once per bit period. Coding is either alternate mark inversion (AMI) or AMI with the eight-zero substitution (B8ZS). Three maintenance controls can take over the transmit output:

- **Violation insert.** A rising edge on this control plants one bipolar violation on a later data mark.
- **Force loss-of-signal.** The line is held silent.
- **Local loopback.** An all-ones signal is sent toward the line.

The receive side accepts the rails back from the line. It removes B8ZS substitutions, recovers the unipolar data and gives a one-cycle strobe for every bipolar violation that is not part of a valid substitution.

Both directions work on a window of eight bit periods, so each path adds eight bit-enable periods of latency. All state advances only on the bit-clock enable `bit_en`. `rx_viol` is the one exception: it is cleared on the clock after its strobe.

The violation control has its own three-state machine:

- **VI_IDLE → VI_ARMED** when the control is seen high.
- **VI_ARMED → VI_HELD**, or **VI_ARMED → VI_IDLE** if the control has already returned low, when a data mark carries the violation.
- **VI_HELD → VI_IDLE** when the control returns low.

The transmit output mode is chosen each period from the overrides:

- **LM_SILENT** when force-LOS is set.
- **LM_ONES** when local loopback is set and force-LOS is not.
- **LM_DATA** otherwise.

Each receive slot leaving the window is classed as one of:

- **RS_SPACE**: no mark.
- **RS_SUBST**: part of a removed substitution.
- **RS_DATA**: a normal mark.
- **RS_BAD**: a violation.

Top module: `t1_line_codec`

## Requirements
- R1: With `tx_ami_sel`=0, each run of eight data zeros (counted from the first bit accepted after reset, greedily in blocks of eight) is sent as 000VB0VB. V is a mark of the same polarity as the preceding mark and B is a mark of the opposite polarity. A bit accepted on bit-enable k appears on the rails on bit-enable k+8.
- R2: With `tx_ami_sel`=1, a one is sent as a mark of polarity opposite to the previous mark and a zero as a space, with the same 8-period latency. A positive mark is `line_pos`=1, `line_neg`=0. A negative mark is `line_pos`=0, `line_neg`=1. A space is both low.
- R3: The rails are registered, change only on a clock edge where `bit_en` is high, and are never both high.
- R4: Each 0-to-1 change of `viol_req` places exactly one violation. It goes on the next data mark that is not part of a substitution, which is sent with the same polarity as the previous mark. Holding `viol_req` high adds no more. After reset the control is taken as previously low.
- R5: While `force_los` is high, both rails are low, whatever `local_loop` is.
- R6: While `local_loop` is high and `force_los` is low, marks of alternating polarity are sent every period regardless of the data.
- R7: With `rx_ami_sel`=0, the receiver turns each valid 000VB0VB pattern back into eight zeros. A rail pair sampled on bit-enable k is decoded onto `rx_data` on bit-enable k+8, so transmit data looped back returns on bit-enable k+17.
- R8: With `rx_ami_sel`=1, no substitution is removed, and each V of a received substitution is reported as a violation.
- R9: `rx_viol` is high for exactly one clock, right after the bit-enable on which the offending mark is decoded. An offending mark is a mark of the same polarity as the previous mark, or both rails high (decoded as a one that does not change the polarity history), and it is not inside a removed substitution.
- R10: After reset both rails, `rx_data` and `rx_viol` are low. The polarity history on both sides starts as negative, so the first transmitted mark is positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one pulse per bit period |
| tx_data | input | 1 | Unipolar transmit bit |
| tx_ami_sel | input | 1 | 0 = B8ZS transmit coding, 1 = plain AMI |
| viol_req | input | 1 | A rising edge inserts one code violation |
| force_los | input | 1 | Send all spaces (loss-of-signal) |
| local_loop | input | 1 | Send all ones toward the line |
| line_pos | output | 1 | Transmit positive-rail pulse |
| line_neg | output | 1 | Transmit negative-rail pulse |
| rx_line_pos | input | 1 | Received positive-rail pulse |
| rx_line_neg | input | 1 | Received negative-rail pulse |
| rx_ami_sel | input | 1 | 0 = remove B8ZS on receive, 1 = plain AMI |
| rx_data | output | 1 | Decoded unipolar receive bit |
| rx_viol | output | 1 | One-clock violation strobe |

## Verification
The bench compares the coded line against a model built from the whole input sequence. That model covers runs of exactly seven and exactly eight zeros, back-to-back substitution blocks and data that starts right after reset. A coder that counted a run across a finished block, or let reset fill start a run, would put V and B marks in the wrong periods. Violation insertion is exercised while transmit substitutions are in flight and with the control held high for many periods. A wrong design would mark a V or B, add a violation for every period the control is high, or miss a second edge. On receive, the bench checks the double-rail-high case, that plain AMI decoding reports exactly two violations per substitution, and that the strobe is a single clock wide.

// File: rtl/t1lc_pkg.sv
package t1lc_pkg;

    // Length of the zero run replaced by one substitution block.
    localparam int SUBST_LEN = 8;
    localparam int FILL_W    = $clog2(SUBST_LEN + 1);

    // Transmit window symbol tags.
    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,
        SYM_MARK  = 2'd1,
        SYM_VIOL  = 2'd2,
        SYM_BAL   = 2'd3
    } enc_sym_t;

    // Violation request state machine.
    typedef enum logic [1:0] {
        VI_IDLE  = 2'd0,
        VI_ARMED = 2'd1,
        VI_HELD  = 2'd2
    } vi_state_t;

    // Transmit output mode.
    typedef enum logic [1:0] {
        LM_DATA   = 2'd0,
        LM_SILENT = 2'd1,
        LM_ONES   = 2'd2
    } line_mode_t;

    // Class of a receive slot leaving the window.
    typedef enum logic [1:0] {
        RS_SPACE = 2'd0,
        RS_DATA  = 2'd1,
        RS_SUBST = 2'd2,
        RS_BAD   = 2'd3
    } rx_class_t;

    typedef struct packed {
        logic mark;  // at least one rail high
        logic pos;   // positive polarity
        logic dbl;   // both rails high
        logic clr;   // absorbed into a removed substitution
    } rx_slot_t;

    // Substitution symbol per window slot, slot 0 being the newest.
    function automatic enc_sym_t subst_sym(input int idx);
        enc_sym_t s;
        case (idx)
            0, 3:    s = SYM_BAL;
            1, 4:    s = SYM_VIOL;
            default: s = SYM_SPACE;
        endcase
        return s;
    endfunction

    // Slots whose mark is opposite to the mark preceding the block.
    function automatic logic subst_flip(input int idx);
        return (idx == 1) || (idx == 3);
    endfunction

endpackage

// File: rtl/t1lc_viol_fsm.sv
module t1lc_viol_fsm
    import t1lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic take,
    output logic armed
);

    vi_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VI_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VI_IDLE:  if (req)  state_d = VI_ARMED;
            VI_ARMED: if (take) state_d = req ? VI_HELD : VI_IDLE;
            VI_HELD:  if (!req) state_d = VI_IDLE;
            default:            state_d = VI_IDLE;
        endcase
    end

    always_comb begin
        armed = (state_q == VI_ARMED);
    end

    // R4: a request still held high never re-arms the injector
    a_r4_no_rearm_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VI_HELD && req) |=> (state_q != VI_ARMED));

    // R4: an armed injector stays armed until a mark takes it
    a_r4_armed_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VI_ARMED && !take) |=> (state_q == VI_ARMED));

endmodule

// File: rtl/t1lc_encoder.sv
module t1lc_encoder
    import t1lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic tx_bit,
    input  logic ami_only,
    input  logic viol_req,
    input  logic force_los,
    input  logic local_loop,
    output logic tx_pos,
    output logic tx_neg
);

    enc_sym_t          win_q [SUBST_LEN];
    enc_sym_t          win_d [SUBST_LEN];
    logic [FILL_W-1:0] fill_q;
    logic              last_pos_q;
    logic              run_ok;
    enc_sym_t          head;
    line_mode_t        mode;
    logic              mark, pol, take, armed;

    t1lc_viol_fsm u_viol (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (viol_req),
        .take  (take),
        .armed (armed)
    );

    // Look-ahead window: a new zero completing eight real zeros
    // rewrites the whole window as a substitution block.
    always_comb begin
        run_ok = !ami_only && !tx_bit && (fill_q >= FILL_W'(SUBST_LEN - 1));
        for (int i = 0; i < SUBST_LEN - 1; i++) begin
            if (win_q[i] != SYM_SPACE) run_ok = 1'b0;
        end
        win_d[0] = run_ok ? subst_sym(0) : (tx_bit ? SYM_MARK : SYM_SPACE);
        for (int i = 1; i < SUBST_LEN; i++) begin
            win_d[i] = run_ok ? subst_sym(i) : win_q[i-1];
        end
    end

    always_comb begin
        head = win_q[SUBST_LEN-1];
        if (force_los)       mode = LM_SILENT;
        else if (local_loop) mode = LM_ONES;
        else                 mode = LM_DATA;
    end

    always_comb begin
        mark = 1'b0;
        pol  = 1'b0;
        take = 1'b0;
        unique case (mode)
            LM_SILENT: ;
            LM_ONES: begin
                mark = 1'b1;
                pol  = !last_pos_q;
            end
            LM_DATA: begin
                unique case (head)
                    SYM_SPACE: ;
                    SYM_MARK: begin
                        mark = 1'b1;
                        if (armed) begin
                            pol  = last_pos_q;
                            take = bit_en;
                        end else begin
                            pol  = !last_pos_q;
                        end
                    end
                    SYM_VIOL: begin
                        mark = 1'b1;
                        pol  = last_pos_q;
                    end
                    SYM_BAL: begin
                        mark = 1'b1;
                        pol  = !last_pos_q;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SUBST_LEN; i++) win_q[i] <= SYM_SPACE;
            fill_q     <= '0;
            last_pos_q <= 1'b0;
            tx_pos     <= 1'b0;
            tx_neg     <= 1'b0;
        end else if (bit_en) begin
            for (int i = 0; i < SUBST_LEN; i++) win_q[i] <= win_d[i];
            if (fill_q != FILL_W'(SUBST_LEN)) fill_q <= fill_q + 1'b1;
            if (mark) last_pos_q <= pol;
            tx_pos <= mark && pol;
            tx_neg <= mark && !pol;
        end
    end

    // R3: rails move only on an enabled edge
    a_r3_rails_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_pos) && $stable(tx_neg)));

    // R3: never both rails at once
    a_r3_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_pos && tx_neg));

    // R5: forced loss-of-signal silences the line
    a_r5_los_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && force_los) |=> (!tx_pos && !tx_neg));

    // R6: loopback sends a mark every period
    a_r6_loop_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && local_loop && !force_los) |=> (tx_pos != tx_neg));

endmodule

// File: rtl/t1lc_decoder.sv
module t1lc_decoder
    import t1lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic ami_only,
    output logic rx_bit,
    output logic rx_viol
);

    rx_slot_t  win_q [SUBST_LEN];
    rx_slot_t  win_s [SUBST_LEN];
    rx_slot_t  win_d [SUBST_LEN];
    rx_slot_t  head;
    logic      last_pos_q, last_d;
    logic      match;
    rx_class_t cls;
    logic      bit_d, viol_d;

    always_comb begin
        head   = win_q[SUBST_LEN-1];
        last_d = last_pos_q;
        if (head.mark && !head.dbl && !head.clr) last_d = head.pos;

        win_s[0].mark = rx_pos | rx_neg;
        win_s[0].pos  = rx_pos & ~rx_neg;
        win_s[0].dbl  = rx_pos & rx_neg;
        win_s[0].clr  = 1'b0;
        for (int i = 1; i < SUBST_LEN; i++) win_s[i] = win_q[i-1];

        // Compare the shifted window with 000VB0VB relative to the
        // last mark that has left the window.
        match = !ami_only;
        for (int i = 0; i < SUBST_LEN; i++) begin
            if (subst_sym(i) == SYM_SPACE) begin
                if (win_s[i].mark) match = 1'b0;
            end else if (!win_s[i].mark || win_s[i].dbl || win_s[i].clr ||
                         (win_s[i].pos != (last_d ^ subst_flip(i)))) begin
                match = 1'b0;
            end
        end

        for (int i = 0; i < SUBST_LEN; i++) begin
            win_d[i] = win_s[i];
            if (match) win_d[i].clr = 1'b1;
        end
    end

    always_comb begin
        if (!head.mark)                            cls = RS_SPACE;
        else if (head.clr)                         cls = RS_SUBST;
        else if (head.dbl || head.pos == last_pos_q) cls = RS_BAD;
        else                                       cls = RS_DATA;

        bit_d  = 1'b0;
        viol_d = 1'b0;
        unique case (cls)
            RS_SPACE: ;
            RS_SUBST: ;
            RS_DATA:  bit_d = 1'b1;
            RS_BAD: begin
                bit_d  = 1'b1;
                viol_d = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SUBST_LEN; i++) win_q[i] <= '0;
            last_pos_q <= 1'b0;
            rx_bit     <= 1'b0;
            rx_viol    <= 1'b0;
        end else begin
            rx_viol <= bit_en && viol_d;
            if (bit_en) begin
                for (int i = 0; i < SUBST_LEN; i++) win_q[i] <= win_d[i];
                last_pos_q <= last_d;
                rx_bit     <= bit_d;
            end
        end
    end

    // R9: strobe only follows an enabled edge
    a_r9_strobe_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        rx_viol |-> $past(bit_en));

    // R7: decoded bit holds between enables
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(rx_bit));

endmodule

// File: rtl/t1_line_codec.sv
module t1_line_codec
    import t1lc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic tx_data,
    input  logic tx_ami_sel,
    input  logic viol_req,
    input  logic force_los,
    input  logic local_loop,
    output logic line_pos,
    output logic line_neg,
    input  logic rx_line_pos,
    input  logic rx_line_neg,
    input  logic rx_ami_sel,
    output logic rx_data,
    output logic rx_viol
);

    t1lc_encoder u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .tx_bit     (tx_data),
        .ami_only   (tx_ami_sel),
        .viol_req   (viol_req),
        .force_los  (force_los),
        .local_loop (local_loop),
        .tx_pos     (line_pos),
        .tx_neg     (line_neg)
    );

    t1lc_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_pos   (rx_line_pos),
        .rx_neg   (rx_line_neg),
        .ami_only (rx_ami_sel),
        .rx_bit   (rx_data),
        .rx_viol  (rx_viol)
    );

endmodule

// File: tb/t1_line_codec_bench.sv
module t1_line_codec_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int SEQ_N = 56;
    // bit 32 = AMI select, bits 31:0 = data sent MSB first
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 32'hFFFFFFFF},
        {1'b0, 32'h00000000},
        {1'b1, 32'h00000000},
        {1'b0, 32'h80000001},
        {1'b0, 32'h00FFFFFF},
        {1'b0, 32'h01FFFFFF},
        {1'b1, 32'hA5A5A5A5},
        {1'b0, 32'h0000FF00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, tx_data = 1'b0, tx_ami_sel = 1'b0, viol_req = 1'b0;
    logic force_los = 1'b0, local_loop = 1'b0, rx_ami_sel = 1'b0;
    logic drive_rx = 1'b0, drv_pos = 1'b0, drv_neg = 1'b0;
    logic line_pos, line_neg, rx_data, rx_viol;
    logic rx_pos_w, rx_neg_w;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;
    logic s_pos, s_neg, s_rxb, s_rxv;
    logic seq_in [64];
    logic exp_p [64];
    logic exp_n [64];

    assign rx_pos_w = drive_rx ? drv_pos : line_pos;
    assign rx_neg_w = drive_rx ? drv_neg : line_neg;

    always #(CLK_PERIOD/2) clk = ~clk;

    t1_line_codec u_t1_line_codec (
        .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .tx_data (tx_data),
        .tx_ami_sel (tx_ami_sel), .viol_req (viol_req), .force_los (force_los),
        .local_loop (local_loop), .line_pos (line_pos), .line_neg (line_neg),
        .rx_line_pos (rx_pos_w), .rx_line_neg (rx_neg_w), .rx_ami_sel (rx_ami_sel),
        .rx_data (rx_data), .rx_viol (rx_viol)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; tx_data = 1'b0; viol_req = 1'b0;
        force_los = 1'b0; local_loop = 1'b0; drive_rx = 1'b0;
        drv_pos = 1'b0; drv_neg = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "reset line_pos", int'(line_pos), 0);
        check("R10", "reset line_neg", int'(line_neg), 0);
        check("R10", "reset rx_data", int'(rx_data), 0);
        check("R10", "reset rx_viol", int'(rx_viol), 0);
    endtask

    // One bit period of four clocks; outputs sampled on the falling edge
    // right after the enabled rising edge.
    task automatic step(input logic b);
        tx_data = b;
        bit_en  = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        s_pos = line_pos; s_neg = line_neg; s_rxb = rx_data; s_rxv = rx_viol;
        @(negedge clk);
        check("R9", "strobe width", int'(rx_viol), 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Line model from the requirements: 0 space, 1 data mark, 2 V, 3 B.
    task automatic build_expect(input logic ami, input int n);
        int typ [64];
        int zrun;
        logic last, pol;
        zrun = 0;
        last = 1'b0;
        for (int i = 0; i < n; i++) begin
            typ[i] = seq_in[i] ? 1 : 0;
            if (!ami && !seq_in[i]) begin
                zrun++;
                if (zrun == 8) begin
                    typ[i-7] = 0; typ[i-6] = 0; typ[i-5] = 0; typ[i-4] = 2;
                    typ[i-3] = 3; typ[i-2] = 0; typ[i-1] = 2; typ[i]   = 3;
                    zrun = 0;
                end
            end else begin
                zrun = 0;
            end
        end
        for (int k = 0; k < n; k++) begin
            exp_p[k] = 1'b0;
            exp_n[k] = 1'b0;
            if (k >= 8 && typ[k-8] != 0) begin
                pol = (typ[k-8] == 2) ? last : !last;
                exp_p[k] = pol;
                exp_n[k] = !pol;
                last = pol;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        int same_cnt, viol_cnt;
        logic blast;

        // R1 R2 R7 R10: vector table through loopback
        for (int v = 0; v < NVEC; v++) begin
            tx_ami_sel = VEC[v][32];
            rx_ami_sel = VEC[v][32];
            do_reset();
            for (int i = 0; i < SEQ_N; i++) seq_in[i] = (i < 32) ? VEC[v][31-i] : 1'b1;
            build_expect(VEC[v][32], SEQ_N);
            for (int k = 0; k < SEQ_N; k++) begin
                step(seq_in[k]);
                check(VEC[v][32] ? "R2" : "R1", $sformatf("vec%0d pos k=%0d", v, k), int'(s_pos), int'(exp_p[k]));
                check(VEC[v][32] ? "R2" : "R1", $sformatf("vec%0d neg k=%0d", v, k), int'(s_neg), int'(exp_n[k]));
                check("R7", $sformatf("vec%0d rx_data k=%0d", v, k), int'(s_rxb), (k >= 17) ? int'(seq_in[k-17]) : 0);
                check("R7", $sformatf("vec%0d rx_viol k=%0d", v, k), int'(s_rxv), 0);
            end
        end

        // R4: held request, then a second edge
        tx_ami_sel = 1'b0; rx_ami_sel = 1'b0;
        do_reset();
        same_cnt = 0; viol_cnt = 0; blast = 1'b0;
        for (int k = 0; k < 70; k++) begin
            if (k == 5)  viol_req = 1'b1;
            if (k == 30) viol_req = 1'b0;
            if (k == 34) viol_req = 1'b1;
            step(1'b1);
            if (s_pos || s_neg) begin
                if (s_pos == blast) same_cnt++;
                blast = s_pos;
            end
            if (s_rxv) viol_cnt++;
            if (k == 29) check("R4", "one violation while held", same_cnt, 1);
        end
        check("R4", "violations after second edge", same_cnt, 2);
        check("R9", "rx strobes for two violations", viol_cnt, 2);

        // R4: violation skips substitution marks
        do_reset();
        viol_req = 1'b1;
        viol_cnt = 0;
        for (int k = 0; k < 44; k++) begin
            step((k >= 16) ? 1'b1 : 1'b0);
            if (s_rxv) viol_cnt++;
            if (k == 24) begin
                check("R4", "violated mark neg", int'(s_neg), 1);
                check("R4", "violated mark pos", int'(s_pos), 0);
            end
            if (k == 25) check("R4", "mark after violation pos", int'(s_pos), 1);
            if (k >= 17) check("R7", $sformatf("rx_data k=%0d", k), int'(s_rxb), (k - 17 >= 16) ? 1 : 0);
        end
        check("R9", "one strobe for injected violation", viol_cnt, 1);
        viol_req = 1'b0;

        // R5: force-LOS silences, also over loopback
        tx_ami_sel = 1'b1;
        do_reset();
        for (int k = 0; k < 24; k++) begin
            force_los  = (k >= 10 && k < 20);
            local_loop = (k >= 15 && k < 20);
            step(1'b1);
            if (k >= 10 && k < 20) begin
                check("R5", $sformatf("los pos k=%0d", k), int'(s_pos), 0);
                check("R5", $sformatf("los neg k=%0d", k), int'(s_neg), 0);
            end
            if (k == 20) check("R5", "traffic resumes", int'(s_pos ^ s_neg), 1);
        end
        force_los = 1'b0; local_loop = 1'b0;

        // R6: all-ones loopback over zero data
        do_reset();
        for (int k = 0; k < 16; k++) begin
            local_loop = (k < 12);
            step(1'b0);
            if (k < 12) begin
                check("R6", $sformatf("loop pos k=%0d", k), int'(s_pos), (k % 2 == 0) ? 1 : 0);
                check("R6", $sformatf("loop neg k=%0d", k), int'(s_neg), (k % 2 == 1) ? 1 : 0);
            end else begin
                check("R6", $sformatf("after loop k=%0d", k), int'(s_pos | s_neg), 0);
            end
        end
        local_loop = 1'b0;

        // R8: AMI receive of a B8ZS line reports each V
        tx_ami_sel = 1'b0; rx_ami_sel = 1'b1;
        do_reset();
        viol_cnt = 0;
        for (int k = 0; k < 80; k++) begin
            step((k >= 40) ? 1'b1 : 1'b0);
            if (s_rxv) viol_cnt++;
        end
        check("R8", "two violations per block, five blocks", viol_cnt, 10);

        // R9: direct rails, double-high and same-polarity marks
        do_reset();
        drive_rx = 1'b1;
        for (int k = 0; k < 16; k++) begin
            drv_pos = (k == 0) || (k == 1) || (k == 4) || (k == 5);
            drv_neg = (k == 1) || (k == 2);
            step(1'b0);
            if (k >= 8) begin
                check("R9", $sformatf("direct rx_data k=%0d", k), int'(s_rxb),
                      (k == 8 || k == 9 || k == 10 || k == 12 || k == 13) ? 1 : 0);
                check("R9", $sformatf("direct rx_viol k=%0d", k), int'(s_rxv),
                      (k == 9 || k == 13) ? 1 : 0);
            end
        end
        drive_rx = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule